// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address through a two-level page table held in byte-wide memory, and then carries out one byte access at the translated address. The virtual address has three parts. The upper ten bits select an entry in the first-level table. The next ten bits select an entry in the second-level table. The low twelve bits give the offset within a 4 KB page.

Each table entry is a 32-bit word stored big-endian, so the most significant byte sits at the lowest address. The walker fetches the four bytes of each entry one after another and checks the permission flags of the entry at each level. It then performs a load, a store or a test-and-set, or it stops with one of three error classes.

A client offers one request at a time on a valid/ready request port. The request carries the virtual address, the operation, the store byte and the privilege mode. The table base frame is sampled when the request is accepted. The block keeps no translation cache. It does not update the accessed or dirty bits, and it has no large-page support.

Top module: `pt_walker`

## Requirements
- R1: The first-level entry is read at (table base frame << 12) + 4 × vaddr[31:22]. The second-level entry is read at (first-level entry bits [31:12] << 12) + 4 × vaddr[21:12]. The data byte is accessed at {second-level entry bits [31:12], vaddr[11:0]}.
- R2: An entry is assembled from four single-byte reads at ascending addresses. The byte at the lowest address becomes bits [31:24]. Read data is taken one cycle after `mem_rd`. `mem_rd` and `mem_wr` are never high together.
- R3: If the valid flag (entry bit 0) is clear at either level, the response has status invalid (code 1) and data 0x00, and no memory write takes place. The valid check is made before any other check at that level. The first level is fully checked before the second level is read.
- R4: With `req_user`=1, a clear user flag (entry bit 2) at either level gives status kernel-only (code 3) with no write. With `req_user`=0, the user flag has no effect.
- R5: A store (op 1) or test-and-set (op 2) whose entry has the writeable flag (bit 1) clear gives status read-only (code 2) with no write. This check comes after the user check at the same level. Loads ignore the writeable flag.
- R6: A load (op 0) that passes all checks returns the byte at the physical address with status ok (code 0). Op code 3 is handled as a load.
- R7: A store that passes all checks writes `req_wdata` to the physical address exactly once and returns status ok with data 0x00.
- R8: A test-and-set that passes all checks returns the old byte, then writes 0x01 to the same address exactly once, with status ok.
- R9: Entry bits [11:3] (software bits, large page, dirty, accessed, no-cache, write-through) have no effect on the walk or the result.
- R10: Only one request is in flight at a time. `req_ready` drops in the cycle after acceptance and stays low until the cycle in which `rsp_valid` is high. `rsp_valid` is a one-cycle pulse.
- R11: After reset, `req_ready` is high and `rsp_valid`, `mem_rd` and `mem_wr` are low. No memory strobe is issued while the walker is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_base | input | 20 | Frame number of the first-level table, sampled on acceptance |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_op | input | 2 | 0 load, 1 store, 2 test-and-set, 3 load |
| req_wdata | input | 8 | Store byte |
| req_user | input | 1 | 1 for user mode, 0 for kernel mode |
| mem_rd | output | 1 | Byte read strobe; data returns the next cycle |
| mem_wr | output | 1 | Byte write strobe |
| mem_addr | output | 32 | Physical byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read data, one cycle after `mem_rd` |
| rsp_valid | output | 1 | Response pulse |
| rsp_status | output | 2 | 0 ok, 1 invalid, 2 read-only, 3 kernel-only |
| rsp_data | output | 8 | Loaded or old byte; 0x00 otherwise |

## Verification
The bench sweeps all eight combinations of the valid, writeable and user flags at the first level, crossed with all eight at the second level, for every operation in both privilege modes. This sweep separates the check order within a level from the order between levels, because a write fault at the first level must win over an invalid second-level entry. The entries carry a unique page number per table and varied values in the ignored bits. A byte-order or address-formation fault therefore lands on the wrong data byte or outside the modelled memory. Store and test-and-set cases write a byte that differs from the old one, and the write strobes are counted, so a missing, doubled or leaked write can be seen at the memory port.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_TAS   = 2'd2,
    OP_LOAD2 = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_OK       = 2'd0,
    ST_INVALID  = 2'd1,
    ST_READONLY = 2'd2,
    ST_KERNEL   = 2'd3
  } status_e;

  // positions of the permission flags inside an entry
  localparam int FLAG_VALID = 0;
  localparam int FLAG_WRITE = 1;
  localparam int FLAG_USER  = 2;
  localparam int FLAG_W     = 3;

  localparam logic [7:0] TAS_SET_VALUE = 8'h01;

  function automatic logic op_writes(input logic [1:0] op);
    return (op == OP_STORE) || (op == OP_TAS);
  endfunction

endpackage

// File: rtl/pt_perm_check.sv
module pt_perm_check
  import pt_walker_pkg::*;
(
  input  logic [FLAG_W-1:0] flags,
  input  logic [1:0]        op,
  input  logic              user_mode,
  output logic [1:0]        status
);

  always_comb begin
    if (!flags[FLAG_VALID])
      status = ST_INVALID;
    else if (user_mode && !flags[FLAG_USER])
      status = ST_KERNEL;
    else if (op_writes(op) && !flags[FLAG_WRITE])
      status = ST_READONLY;
    else
      status = ST_OK;
  end

endmodule

// File: rtl/pt_pte_collect.sv
module pt_pte_collect #(
  parameter int PTE_W  = 32,
  parameter int BYTE_W = 8,
  parameter int PPN_W  = 20,
  parameter int FLG_W  = 3,
  parameter int CNT_W  = $clog2(PTE_W / BYTE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              shift_en,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [PPN_W-1:0]  ppn,
  output logic [FLG_W-1:0]  flags,
  output logic [CNT_W-1:0]  byte_sel,
  output logic              last
);

  localparam int NBYTES = PTE_W / BYTE_W;

  logic [PTE_W-1:0] word_q;
  logic [CNT_W-1:0] cnt_q;

  // big-endian: earlier byte ends up more significant
  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (shift_en) begin
      word_q <= {word_q[PTE_W-BYTE_W-1:0], byte_in};
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign ppn      = word_q[PTE_W-1 -: PPN_W];
  assign flags    = word_q[FLG_W-1:0];
  assign byte_sel = cnt_q;
  assign last     = (cnt_q == CNT_W'(NBYTES - 1));

endmodule

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
  parameter int IDX_W   = 10,
  parameter int OFF_W   = 12,
  parameter int PPN_W   = 20,
  parameter int ENT_SH  = 2,
  parameter int PA_W    = PPN_W + OFF_W
) (
  input  logic [PPN_W-1:0] base_frame,
  input  logic [IDX_W-1:0] idx1,
  input  logic [PPN_W-1:0] entry_ppn,
  input  logic [IDX_W-1:0] idx2,
  input  logic [OFF_W-1:0] offset,
  output logic [PA_W-1:0]  l1_entry_addr,
  output logic [PA_W-1:0]  l2_entry_addr,
  output logic [PA_W-1:0]  data_addr
);

  assign l1_entry_addr = {base_frame, {OFF_W{1'b0}}} + PA_W'({idx1, {ENT_SH{1'b0}}});
  assign l2_entry_addr = {entry_ppn,  {OFF_W{1'b0}}} + PA_W'({idx2, {ENT_SH{1'b0}}});
  assign data_addr     = {entry_ppn, offset};

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12,
  parameter int PPN_W  = 20,
  parameter int BYTE_W = 8,
  parameter int PTE_W  = 32,
  parameter int VA_W   = 2 * IDX_W + OFF_W,
  parameter int PA_W   = PPN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PPN_W-1:0]  tbl_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [1:0]        req_op,
  input  logic [BYTE_W-1:0] req_wdata,
  input  logic              req_user,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [PA_W-1:0]   mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic [BYTE_W-1:0] rsp_data
);

  localparam int NBYTES = PTE_W / BYTE_W;
  localparam int CNT_W  = $clog2(NBYTES);
  localparam int ENT_SH = $clog2(NBYTES);

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CAPT, S_CHECK, S_DRD, S_DCAPT, S_DWR
  } state_e;

  state_e            state_q;
  logic              lvl_q;
  logic [1:0]        op_q;
  logic              user_q;
  logic [BYTE_W-1:0] wdata_q;
  logic [IDX_W-1:0]  idx2_q;
  logic [OFF_W-1:0]  off_q;
  logic [PA_W-1:0]   entry_q;
  logic [PA_W-1:0]   paddr_q;
  logic [BYTE_W-1:0] old_q;

  logic              accept;
  logic              col_clear, col_shift;
  logic [PPN_W-1:0]  ent_ppn;
  logic [FLAG_W-1:0] ent_flags;
  logic [CNT_W-1:0]  byte_sel;
  logic              byte_last;
  logic [1:0]        chk_status;
  logic [PA_W-1:0]   l1_addr, l2_addr, data_addr;

  assign req_ready = (state_q == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign col_clear = accept || (state_q == S_CHECK);
  assign col_shift = (state_q == S_CAPT);

  pt_pte_collect #(
    .PTE_W(PTE_W), .BYTE_W(BYTE_W), .PPN_W(PPN_W), .FLG_W(FLAG_W), .CNT_W(CNT_W)
  ) u_collect (
    .clk(clk), .rst(rst), .clear(col_clear), .shift_en(col_shift),
    .byte_in(mem_rdata), .ppn(ent_ppn), .flags(ent_flags),
    .byte_sel(byte_sel), .last(byte_last)
  );

  pt_perm_check u_perm (
    .flags(ent_flags), .op(op_q), .user_mode(user_q), .status(chk_status)
  );

  pt_addr_gen #(
    .IDX_W(IDX_W), .OFF_W(OFF_W), .PPN_W(PPN_W), .ENT_SH(ENT_SH), .PA_W(PA_W)
  ) u_addr (
    .base_frame(tbl_base),
    .idx1(req_vaddr[VA_W-1 -: IDX_W]),
    .entry_ppn(ent_ppn),
    .idx2(idx2_q),
    .offset(off_q),
    .l1_entry_addr(l1_addr),
    .l2_entry_addr(l2_addr),
    .data_addr(data_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      lvl_q      <= 1'b0;
      op_q       <= 2'd0;
      user_q     <= 1'b0;
      wdata_q    <= '0;
      idx2_q     <= '0;
      off_q      <= '0;
      entry_q    <= '0;
      paddr_q    <= '0;
      old_q      <= '0;
      rsp_valid  <= 1'b0;
      rsp_status <= 2'd0;
      rsp_data   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state_q)
        S_IDLE: if (accept) begin
          op_q    <= req_op;
          user_q  <= req_user;
          wdata_q <= req_wdata;
          idx2_q  <= req_vaddr[OFF_W +: IDX_W];
          off_q   <= req_vaddr[OFF_W-1:0];
          entry_q <= l1_addr;
          lvl_q   <= 1'b0;
          state_q <= S_FETCH;
        end
        S_FETCH: state_q <= S_CAPT;
        S_CAPT:  state_q <= byte_last ? S_CHECK : S_FETCH;
        S_CHECK: begin
          if (chk_status != ST_OK) begin
            rsp_valid  <= 1'b1;
            rsp_status <= chk_status;
            rsp_data   <= '0;
            state_q    <= S_IDLE;
          end else if (!lvl_q) begin
            entry_q <= l2_addr;
            lvl_q   <= 1'b1;
            state_q <= S_FETCH;
          end else begin
            paddr_q <= data_addr;
            state_q <= (op_q == OP_STORE) ? S_DWR : S_DRD;
          end
        end
        S_DRD: state_q <= S_DCAPT;
        S_DCAPT: begin
          old_q <= mem_rdata;
          if (op_q == OP_TAS) begin
            state_q <= S_DWR;
          end else begin
            rsp_valid  <= 1'b1;
            rsp_status <= ST_OK;
            rsp_data   <= mem_rdata;
            state_q    <= S_IDLE;
          end
        end
        S_DWR: begin
          rsp_valid  <= 1'b1;
          rsp_status <= ST_OK;
          rsp_data   <= (op_q == OP_TAS) ? old_q : '0;
          state_q    <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state_q)
      S_FETCH: begin
        mem_rd   = 1'b1;
        mem_addr = entry_q + PA_W'(byte_sel);
      end
      S_DRD: begin
        mem_rd   = 1'b1;
        mem_addr = paddr_q;
      end
      S_DWR: begin
        mem_wr    = 1'b1;
        mem_addr  = paddr_q;
        mem_wdata = (op_q == OP_TAS) ? TAS_SET_VALUE : wdata_q;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_ready,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       rsp_valid,
  input logic [1:0] rsp_status,
  input logic [7:0] rsp_data
);

  // R10: once accepted, the walker stops taking requests
  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R10: the response cycle is also the cycle the walker reopens
  a_r10_ready_with_rsp: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> req_ready);

  // R10: one-cycle response pulse
  a_r10_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R2: read and write strobes are exclusive
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  // R11: no memory traffic while idle
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!mem_rd && !mem_wr));

  // R3: an error response carries zero data
  a_r3_err_zero_data: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status != 2'd0) |-> (rsp_data == 8'h00));

endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .rsp_valid(rsp_valid),
  .rsp_status(rsp_status), .rsp_data(rsp_data)
);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] tbl_base = 20'd1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_op = 2'd0;
  logic [7:0]  req_wdata = '0;
  logic        req_user = 1'b0;
  logic        mem_rd, mem_wr;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;
  logic        rsp_valid;
  logic [1:0]  rsp_status;
  logic [7:0]  rsp_data;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  int wr_count = 0;
  int bad_addr = 0;
  logic [7:0] mem [512];

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker dut (
    .clk(clk), .rst(rst), .tbl_base(tbl_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_op(req_op), .req_wdata(req_wdata), .req_user(req_user),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_data(rsp_data)
  );

  // first-level entry i: frame 2, flags = i, varied ignored bits (R9)
  function automatic logic [31:0] l1_word(input int i);
    return {20'd2, 3'(i), 1'b0, 1'(i & 1), 4'(i * 3), 3'(i)};
  endfunction

  // second-level entry j: frame 4 + j[1:0], flags = j
  function automatic logic [31:0] l2_word(input int j);
    return {20'(4 + (j & 3)), 3'(~j), 1'b0, 1'((j >> 1) & 1), 4'(j * 5), 3'(j)};
  endfunction

  function automatic logic [7:0] init_byte(input int k);
    int page, off;
    logic [31:0] w;
    page = k / 64;
    off  = k % 64;
    if (page == 1 && off < 32) begin
      w = l1_word(off / 4);
      return w[31 - 8*(off % 4) -: 8];
    end else if (page == 2 && off < 32) begin
      w = l2_word(off / 4);
      return w[31 - 8*(off % 4) -: 8];
    end
    return 8'(page * 41 + off * 7 + 3);
  endfunction

  function automatic int midx(input logic [31:0] a);
    return int'({a[14:12], a[5:0]});
  endfunction

  function automatic bit legal(input logic [31:0] a);
    return (a[31:15] == 0) && (a[11:6] == 0);
  endfunction

  // byte-wide memory, one-cycle read latency
  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 512; k++) mem[k] <= init_byte(k);
      mem_rdata <= 8'h00;
    end else begin
      if (mem_rd) mem_rdata <= mem[midx(mem_addr)];
      if (mem_wr) begin
        mem[midx(mem_addr)] <= mem_wdata;
        wr_count <= wr_count + 1;
      end
      if ((mem_rd || mem_wr) && !legal(mem_addr)) bad_addr <= bad_addr + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected status: level 1 fully checked before level 2 (R3, R4, R5)
  function automatic int exp_status(input int f1, input int f2, input int op, input int user);
    int fl[2];
    fl[0] = f1;
    fl[1] = f2;
    for (int l = 0; l < 2; l++) begin
      if ((fl[l] & 1) == 0) return 1;
      if (user != 0 && (fl[l] & 4) == 0) return 3;
      if ((op == 1 || op == 2) && (fl[l] & 2) == 0) return 2;
    end
    return 0;
  endfunction

  task automatic run_one(input int i, input int j, input int op, input int user);
    logic [31:0] va, pa;
    logic [7:0]  old, wd;
    int st, ed, w0, n;
    string tag;
    va  = {10'(i), 10'(j), 6'd0, 3'(i), 3'(j)};
    pa  = {20'(4 + (j & 3)), 6'd0, 3'(i), 3'(j)};
    old = mem[midx(pa)];
    wd  = old ^ 8'h5A;
    st  = exp_status(i, j, op, user);
    if (st != 0) ed = 0;
    else if (op == 1) ed = 0;
    else ed = int'(old);
    tag = (st == 1) ? "R3" : (st == 3) ? "R4" : (st == 2) ? "R5" :
          (op == 1) ? "R7" : (op == 2) ? "R8" : "R6";
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    w0 = wr_count;
    req_valid = 1'b1;
    req_vaddr = va;
    req_op    = 2'(op);
    req_wdata = wd;
    req_user  = 1'(user);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10 busy", int'(req_ready), 0);
    n = 0;
    while (!rsp_valid && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(rsp_valid == 1'b1, "R10 response", int'(rsp_valid), 1);
    chk(req_ready == 1'b1, "R10 ready with response", int'(req_ready), 1);
    // R1 R2 R9: status and data come from the right bytes
    chk(int'(rsp_status) == st && int'(rsp_data) == ed,
        {tag, " status/data"}, int'({rsp_status, rsp_data}), (st << 8) | ed);
    chk(wr_count - w0 == ((st == 0 && (op == 1 || op == 2)) ? 1 : 0),
        {tag, " write count"}, wr_count - w0,
        (st == 0 && (op == 1 || op == 2)) ? 1 : 0);
    if (st == 0 && op == 1)
      chk(mem[midx(pa)] == wd, "R7 stored byte", int'(mem[midx(pa)]), int'(wd));
    else if (st == 0 && op == 2)
      chk(mem[midx(pa)] == 8'h01, "R8 set byte", int'(mem[midx(pa)]), 1);
    else
      chk(mem[midx(pa)] == old, {tag, " byte untouched"}, int'(mem[midx(pa)]), int'(old));
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R10 pulse", int'(rsp_valid), 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        fails++;
        tests++;
        $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(req_ready == 1'b1, "R11 ready", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R11 rsp_valid", int'(rsp_valid), 0);
    chk(mem_rd == 1'b0 && mem_wr == 1'b0, "R11 strobes", int'({mem_rd, mem_wr}), 0);
    for (int user = 0; user < 2; user++)
      for (int op = 0; op < 4; op++)
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < 8; j++)
            run_one(i, j, op, user);
    // R1 R2: every access stayed inside the modelled tables and pages
    chk(bad_addr == 0, "R1 address range", bad_addr, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule